// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the device-side command logic for the erase path of a serial flash memory. It watches chip select, serial clock and serial data input, all already synchronised to the system clock. It counts the bits of each frame and keeps the 8-bit command byte that opens it. When chip select goes high it decides whether that frame was a complete, legal erase, write-enable, suspend or resume command.

Erases need the write-enable latch to be set. They are checked against per-sector protection inputs. Each one runs a self-timed countdown, and at the end it sends a one-cycle erase strobe with the target to a behavioural memory array. The array then sets every byte of that region to FFh. A sector erase can be paused and resumed, and a whole-array erase cannot. A status read command can be given at any time. It returns a status byte, most significant bit first, on the serial output.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A frame of exactly 8 bits carrying 06h sets the write-enable latch, reported as status bit 1. A frame of any other length does not set it. An erase received while the latch is clear is ignored.
- R2: A sector erase is D8h followed by a 24-bit address sent MSB first. It starts only if chip select rises after exactly 32 bits. A 31-bit or 33-bit frame is ignored and leaves the latch set.
- R3: A bulk erase is C7h. It starts only if chip select rises after exactly 8 bits, and a 9-bit frame is ignored.
- R4: `erase_stb` is high for one cycle, T_SE (sector) or T_BE (bulk) clock cycles after the first rising clock edge that samples `cs_n` high. At the same time `erase_all` is 1 for bulk and 0 for sector, and `erase_sect` equals address bits [SECT_AW+SIDX_W-1:SECT_AW].
- R5: A status read (05h) drives the status byte on `sdo`, MSB first, starting after the eighth clock rise. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and the other bits are 0. The byte repeats every 8 further clocks. `sdo` is 0 while `cs_n` is high.
- R6: Write-in-progress reads 1 for the whole running erase. The write-enable latch clears when the erase ends, so status reads 00h afterwards.
- R7: A sector erase to a sector whose `prot` bit is 1 is ignored. A bulk erase is ignored if any `prot` bit is 1.
- R8: A suspend (75h, 8 bits) during a sector erase freezes the remaining count, and write-in-progress then reads 0. A resume (7Ah, 8 bits) continues the count. The strobe is delayed by the suspended span plus one cycle.
- R9: A suspend during a bulk erase has no effect, and the strobe comes after exactly T_BE.
- R10: Erase commands are ignored while an erase is running or suspended. Unrecognised command bytes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output for status reads |
| prot | input | NSECT | Per-sector protection, 1 = protected |
| erase_stb | output | 1 | One-cycle erase request to the memory array |
| erase_all | output | 1 | With the strobe: 1 = erase whole array |
| erase_sect | output | SIDX_W | With the strobe: index of sector to erase |

## Verification
The bench runs a sector erase on every sector of a 16-sector configuration, with a protection pattern that mixes protected and open sectors. Missing strobes and wrong indices therefore show up per sector. The frame length is varied around each legal length (8 against 9, and 31 and 33 against 32), which separates the exact-boundary rule from a minimum-length rule. Suspend and resume are tried during a sector erase and during a bulk erase, and a second erase is sent while the first is busy. The strobe delay, computed from the measured suspended span, tells a frozen count apart from one that restarts or keeps running.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_SECT   = 8'hD8;
  localparam logic [7:0] OP_BULK   = 8'hC7;
  localparam logic [7:0] OP_STAT   = 8'h05;
  localparam logic [7:0] OP_PAUSE  = 8'h75;
  localparam logic [7:0] OP_RESUME = 8'h7A;

  typedef enum logic [1:0] {TM_IDLE, TM_RUN, TM_HOLD} tm_state_e;
endpackage

// File: rtl/fe_spi_rx.sv
module fe_spi_rx #(
  parameter int SECT_AW = 16,
  parameter int SIDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              bit_rise,
  output logic              cs_rise,
  output logic [5:0]        bcnt,
  output logic              long_f,
  output logic [7:0]        opcode,
  output logic [7:0]        op_next,
  output logic [SIDX_W-1:0] sidx
);
  logic        sck_q, cs_q;
  logic [5:0]  bcnt_q, bcnt_d;
  logic        long_q, long_d;
  logic [31:0] sh_q, sh_d;
  logic [7:0]  op_q, op_d;

  assign bit_rise = sck & ~sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
  assign op_next  = {sh_q[6:0], sdi};

  always_comb begin
    bcnt_d = bcnt_q;
    long_d = long_q;
    sh_d   = sh_q;
    op_d   = op_q;
    if (cs_n) begin
      bcnt_d = '0;
      long_d = 1'b0;
    end else if (bit_rise) begin
      sh_d   = {sh_q[30:0], sdi};
      bcnt_d = bcnt_q + 6'd1;
      if (&bcnt_q) long_d = 1'b1;
      if (bcnt_q == 6'd7 && !long_q) op_d = op_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      bcnt_q <= '0;
      long_q <= 1'b0;
      sh_q   <= '0;
      op_q   <= '0;
    end else begin
      sck_q  <= sck;
      cs_q   <= cs_n;
      bcnt_q <= bcnt_d;
      long_q <= long_d;
      sh_q   <= sh_d;
      op_q   <= op_d;
    end
  end

  assign bcnt   = bcnt_q;
  assign long_f = long_q;
  assign opcode = op_q;
  assign sidx   = sh_q[SECT_AW +: SIDX_W];

  // R2: a deselected frame always restarts the bit count
  assert_bcnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bcnt_q == 6'd0 && !long_q));
endmodule

// File: rtl/fe_stat_tx.sv
module fe_stat_tx
  import fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_rise,
  input  logic [5:0] bcnt,
  input  logic       long_f,
  input  logic [7:0] opcode,
  input  logic [7:0] op_next,
  input  logic [7:0] status,
  output logic       sdo
);
  logic [7:0] tx_q, tx_d;
  logic       past_op, rd_now;

  assign past_op = (bcnt >= 6'd8) || long_f;
  assign rd_now  = (bcnt == 6'd7 && !long_f) ? (op_next == OP_STAT)
                                              : (past_op && opcode == OP_STAT);

  always_comb begin
    tx_d = tx_q;
    if (bit_rise && rd_now) begin
      if (bcnt[2:0] == 3'd7) tx_d = status;
      else                   tx_d = {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign sdo = tx_q[7] & ~cs_n & past_op & (opcode == OP_STAT);

  // R5: output is quiet while deselected
  assert_sdo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo);
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer
  import fe_pkg::*;
#(
  parameter int T_SE = 50000,
  parameter int T_BE = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_se,
  input  logic start_be,
  input  logic pause_req,
  input  logic resume_req,
  output logic busy,
  output logic held,
  output logic done,
  output logic bulk
);
  localparam int TMAX = (T_SE > T_BE) ? T_SE : T_BE;
  localparam int CW   = $clog2(TMAX + 1);

  tm_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           bulk_q, bulk_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bulk_d = bulk_q;
    case (st_q)
      TM_IDLE: if (start_se || start_be) begin
        st_d   = TM_RUN;
        cnt_d  = start_be ? CW'(T_BE - 1) : CW'(T_SE - 1);
        bulk_d = start_be;
      end
      TM_RUN: begin
        if (cnt_q == '0)              st_d = TM_IDLE;
        else if (pause_req && !bulk_q) st_d = TM_HOLD;
        else                          cnt_d = cnt_q - CW'(1);
      end
      TM_HOLD: if (resume_req) st_d = TM_RUN;
      default: st_d = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TM_IDLE;
      cnt_q  <= '0;
      bulk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bulk_q <= bulk_d;
    end
  end

  assign busy = (st_q == TM_RUN);
  assign held = (st_q == TM_HOLD);
  assign done = busy && (cnt_q == '0);
  assign bulk = bulk_q;

  // R8: a paused erase keeps its remaining count
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TM_HOLD) |=> $stable(cnt_q));
  // R9: whole-array erase never enters the paused state
  assert_bulk_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TM_HOLD) |-> !bulk_q);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fe_pkg::*;
#(
  parameter int NSECT   = 256,
  parameter int SECT_AW = 16,
  parameter int T_SE    = 50000,
  parameter int T_BE    = 2000000,
  localparam int SIDX_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  input  logic [NSECT-1:0]  prot,
  output logic              erase_stb,
  output logic              erase_all,
  output logic [SIDX_W-1:0] erase_sect
);
  logic [1:0]        rs_q;
  logic              rst_s_n;
  logic              bit_rise, cs_rise, long_f;
  logic [5:0]        bcnt;
  logic [7:0]        opcode, op_next;
  logic [SIDX_W-1:0] sidx, tgt_q, tgt_d;
  logic              wel_q, wel_d;
  logic              busy, held, done, bulk;
  logic              len8, len32, idle_ok;
  logic              start_se, start_be, wren_ok, pause_req, resume_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  fe_spi_rx #(.SECT_AW(SECT_AW), .SIDX_W(SIDX_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .bit_rise(bit_rise), .cs_rise(cs_rise), .bcnt(bcnt), .long_f(long_f),
    .opcode(opcode), .op_next(op_next), .sidx(sidx)
  );

  fe_stat_tx u_tx (
    .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .bit_rise(bit_rise),
    .bcnt(bcnt), .long_f(long_f), .opcode(opcode), .op_next(op_next),
    .status({6'b0, wel_q, busy}), .sdo(sdo)
  );

  fe_erase_timer #(.T_SE(T_SE), .T_BE(T_BE)) u_tm (
    .clk(clk), .rst_n(rst_s_n), .start_se(start_se), .start_be(start_be),
    .pause_req(pause_req), .resume_req(resume_req),
    .busy(busy), .held(held), .done(done), .bulk(bulk)
  );

  assign len8    = cs_rise && !long_f && (bcnt == 6'd8);
  assign len32   = cs_rise && !long_f && (bcnt == 6'd32);
  assign idle_ok = !busy && !held;

  assign start_se   = len32 && (opcode == OP_SECT) && wel_q && idle_ok && !prot[sidx];
  assign start_be   = len8  && (opcode == OP_BULK) && wel_q && idle_ok && !(|prot);
  assign wren_ok    = len8  && (opcode == OP_WREN) && !busy;
  assign pause_req  = len8  && (opcode == OP_PAUSE);
  assign resume_req = len8  && (opcode == OP_RESUME);

  always_comb begin
    wel_d = wel_q;
    tgt_d = tgt_q;
    if (done)         wel_d = 1'b0;
    else if (wren_ok) wel_d = 1'b1;
    if (start_se)     tgt_d = sidx;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wel_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      wel_q <= wel_d;
      tgt_q <= tgt_d;
    end
  end

  assign erase_stb  = done;
  assign erase_all  = done && bulk;
  assign erase_sect = tgt_q;

  // R1: an erase only starts with the write-enable latch set
  assert_start_needs_wel_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start_se || start_be) |-> wel_q);
  // R6: the latch is clear after the erase ends
  assert_wel_cleared_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    erase_stb |=> (!wel_q && !busy));
  // R10: no second erase launches while one is pending
  assert_single_erase_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy || held) |=> !$rose(erase_stb) || $past(busy));
endmodule

// File: tb/tb_flash_erase_ctrl.sv
module tb_flash_erase_ctrl;
  localparam int NSECT = 16;
  localparam int SAW   = 20;
  localparam int TSE   = 200;
  localparam int TBE   = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [NSECT-1:0] prot = '0;
  logic sdo, erase_stb, erase_all;
  logic [3:0] erase_sect;

  int cyc = 0, total = 0, bad = 0;
  int stb_cnt = 0, stb_cyc = 0, t_rise = 0;
  logic stb_all = 1'b0;
  logic [3:0] stb_sect = '0;
  bit finished = 0;

  flash_erase_ctrl #(.NSECT(NSECT), .SECT_AW(SAW), .T_SE(TSE), .T_BE(TBE)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
    .prot(prot), .erase_stb(erase_stb), .erase_all(erase_all), .erase_sect(erase_sect)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (erase_stb) begin
    stb_cnt  = stb_cnt + 1;
    stb_cyc  = cyc;
    stb_all  = erase_all;
    stb_sect = erase_sect;
  end

  always @(posedge clk) if (!finished && cyc > 150000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog act=%0d exp<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [63:0] d, input int n, output logic [15:0] rx);
    logic so;
    rx = '0;
    @(negedge clk); cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; sdi = d[i];
      @(negedge clk); so = sdo;
      if (i < 16) rx = {rx[14:0], so};
      @(negedge clk); sck = 1'b1;
      @(negedge clk);
    end
    @(negedge clk); sck = 1'b0;
    @(negedge clk); cs_n = 1'b1; t_rise = cyc;
    @(negedge clk);
  endtask

  task automatic cmd8(input logic [7:0] op);
    logic [15:0] r;
    frame({56'd0, op}, 8, r);
  endtask

  task automatic sect_cmd(input logic [23:0] a, input int n);
    logic [15:0] r;
    logic [63:0] d;
    d = {32'd0, 8'hD8, a};
    if (n == 31) d = d >> 1;
    if (n == 33) d = d << 1;
    frame(d, n, r);
  endtask

  task automatic rdsr(output logic [7:0] s, input string tag);
    logic [15:0] r;
    frame({40'd0, 8'h05, 16'd0}, 24, r);
    check(r[15:8] == r[7:0], {tag, " R5 repeat"}, r[7:0], r[15:8]);
    s = r[15:8];
  endtask

  task automatic wait_stb(input int c0, input int lim);
    int k = 0;
    while (stb_cnt == c0 && k < lim) begin @(negedge clk); k++; end
  endtask

  initial begin
    logic [7:0] st;
    int n0, p0, q0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sdo == 1'b0, "R5 reset sdo", sdo, 0);
    check(erase_stb == 1'b0, "R4 reset strobe", erase_stb, 0);
    rdsr(st, "reset"); check(st == 8'h00, "R5 reset status", st, 0);

    // R1: erase without write enable
    n0 = stb_cnt; sect_cmd(24'h300000, 32); repeat (TSE + 20) @(negedge clk);
    check(stb_cnt == n0, "R1 erase without latch", stb_cnt, n0);
    // R10: unknown opcode; R1: 9-bit enable
    cmd8(8'hAB); rdsr(st, "unk"); check(st == 8'h00, "R10 unknown opcode", st, 0);
    begin logic [15:0] r; frame(64'h0C, 9, r); end
    rdsr(st, "wren9"); check(st == 8'h00, "R1 9-bit enable", st, 0);
    cmd8(8'h06); rdsr(st, "wren"); check(st == 8'h02, "R1 enable sets latch", st, 2);

    // R2: wrong frame lengths
    n0 = stb_cnt; sect_cmd(24'h100000, 31); sect_cmd(24'h100000, 33);
    repeat (TSE + 20) @(negedge clk);
    check(stb_cnt == n0, "R2 31/33-bit sector erase", stb_cnt, n0);
    rdsr(st, "len"); check(st == 8'h02, "R2 latch kept", st, 2);

    // sweep of every sector with a protection pattern
    prot = 16'h8421;
    for (int s = 0; s < NSECT; s++) begin
      cmd8(8'h06);
      n0 = stb_cnt;
      sect_cmd({s[3:0], 20'h5A5A5}, 32);
      p0 = t_rise;
      if (prot[s]) begin
        repeat (TSE + 20) @(negedge clk);
        check(stb_cnt == n0, "R7 protected sector", stb_cnt, n0);
        rdsr(st, "prot"); check(st == 8'h02, "R7 latch untouched", st, 2);
      end else begin
        rdsr(st, "busy"); check(st == 8'h03, "R6 busy status", st, 3);
        wait_stb(n0, TSE + 50);
        check(stb_cyc - p0 == TSE, "R4 sector delay", stb_cyc - p0, TSE);
        check(stb_sect == s[3:0] && !stb_all, "R4 sector target", {stb_all, stb_sect}, s);
        rdsr(st, "after"); check(st == 8'h00, "R6 status after erase", st, 0);
      end
    end

    // bulk erase: protection, length, suspend, overlap
    cmd8(8'h06);
    n0 = stb_cnt; cmd8(8'hC7); repeat (TBE + 20) @(negedge clk);
    check(stb_cnt == n0, "R7 bulk with protection", stb_cnt, n0);
    prot = '0;
    begin logic [15:0] r; frame(64'h18E, 9, r); end
    repeat (TBE + 20) @(negedge clk);
    check(stb_cnt == n0, "R3 9-bit bulk", stb_cnt, n0);
    cmd8(8'hC7); p0 = t_rise;
    cmd8(8'h75);
    sect_cmd(24'h700000, 32);
    wait_stb(n0, TBE + 50);
    check(stb_cyc - p0 == TBE, "R9 bulk ignores suspend", stb_cyc - p0, TBE);
    check(stb_all == 1'b1, "R3 bulk flag", stb_all, 1);
    repeat (TSE + 20) @(negedge clk);
    check(stb_cnt == n0 + 1, "R10 erase during busy", stb_cnt, n0 + 1);
    rdsr(st, "bulk"); check(st == 8'h00, "R6 status after bulk", st, 0);

    // R8: suspend / resume of a sector erase
    cmd8(8'h06);
    n0 = stb_cnt; sect_cmd(24'h2ABCDE, 32); n0 = stb_cnt;
    begin int c0; c0 = t_rise;
      repeat (20) @(negedge clk);
      cmd8(8'h75); p0 = t_rise;
      rdsr(st, "held"); check(st == 8'h02, "R8 paused status", st, 2);
      sect_cmd(24'h400000, 32);
      repeat (50) @(negedge clk);
      cmd8(8'h7A); q0 = t_rise;
      wait_stb(n0, TSE + 50);
      check(stb_cyc - c0 == TSE + q0 - p0 + 1, "R8 delay with pause",
            stb_cyc - c0, TSE + q0 - p0 + 1);
      check(stb_sect == 4'd2, "R10 target kept while paused", stb_sect, 2);
    end
    repeat (TSE + 20) @(negedge clk);
    check(stb_cnt == n0 + 1, "R10 single strobe", stb_cnt, n0 + 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule